// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation-cache miss. It reads a first-level (directory) entry, and usually a second-level (table) entry, from memory through one shared read/write port. Along the way it records use of each entry by setting its accessed flag, and on writes it sets the dirty flag of the final entry. Each changed entry is written back to memory. The block checks presence and access rights at every level it visits. It then reports either a physical address together with the final entry, or a fault record.

A request carries the virtual address, a write flag and a user-mode flag. The directory's page frame comes from a base input that is sampled when the request is accepted. One walk runs at a time: `busy` stays high from acceptance until the one-cycle `done` pulse. The result and fault outputs hold their values until the next request is accepted. The memory port holds `memReq` (and `memWe`, address and write data) steady until `memAck` is seen high at a clock edge. Read data is taken in that same cycle.

Top module: `page_walker`

## Requirements
- R1: The first access of every walk is a read at address {dirBase, va[31:22], 2'b00}.
- R2: For a present, permitted directory entry whose bit 7 (big-page) is 0, the next read is at {dirEntry[31:12], va[21:12], 2'b00}.
- R3: For a completed small-page walk, physAddr = {tableEntry[31:12], va[11:0]} and leafEntry equals the table entry as left in memory.
- R4: Every entry used by a completed level gets bit 5 (accessed) set. A write-back takes place only when the entry's value changes, so an entry that already has the required bits costs no write.
- R5: On a write access, bit 6 (dirty) of the final entry is set. On a read access, bit 6 is never changed.
- R6: When the directory entry has bit 7 set, no table read occurs. physAddr = {dirEntry[31:22], va[21:0]}, and leafEntry is the updated directory entry.
- R7: An entry with bit 0 (present) clear ends the walk with fault=1 and faultNotPresent=1. That entry is not written.
- R8: A write to an entry with bit 1 (writable) clear, or a user access to an entry with bit 2 (user) clear, ends the walk with fault=1 and faultNotPresent=0. Both levels are checked, and the offending entry is not written.
- R9: After any walk, faultVaddr, faultWrite and faultUser reproduce the accepted request's address, write flag and user flag.
- R10: busy is high from the cycle after acceptance until done. done lasts exactly one cycle. Request inputs that change while busy have no effect on the running walk.
- R11: After reset, busy, done and memReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken when not busy) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access |
| reqUser | input | 1 | 1 = user-mode access |
| dirBase | input | 20 | Page frame of the directory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Access completes at this edge |
| memRdata | input | 32 | Memory read data |
| fault | output | 1 | Walk ended in a fault |
| faultNotPresent | output | 1 | 1 = missing entry, 0 = protection |
| faultVaddr | output | 32 | Virtual address of the walk |
| faultWrite | output | 1 | Walk was a write |
| faultUser | output | 1 | Walk was user mode |
| physAddr | output | 32 | Translated physical address |
| leafEntry | output | 32 | Final entry as written to memory |

## Verification
The bench sweeps all 32 combinations of present, writable, user, accessed and big-page bits in the directory entry. It crosses them with all 32 combinations of present, writable, user, accessed and dirty bits in the table entry, and with all four read/write and user/supervisor access kinds. Together these cover every fault path and both page sizes. The cases where the accessed or dirty bit is already set show apart a walk that writes back from one that must skip the write. Big-page entries show apart the one-read path from the two-read path. Half the walks stall every other memory acknowledge to exercise holding the port. During every walk the request inputs are flipped to catch any late sampling.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int PRESENT_BIT  = 0;
  localparam int WRITABLE_BIT = 1;
  localparam int USER_BIT     = 2;
  localparam int ACCESSED_BIT = 5;
  localparam int DIRTY_BIT    = 6;
  localparam int BIGPAGE_BIT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB,
    ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadDir;
    logic loadTbl;
    logic markBig;
    logic raiseMiss;
    logic raiseProt;
    logic selTbl;
  } walkCtl_t;

  // per-level evaluation of the entry on the read bus
  typedef struct packed {
    logic present;
    logic permitted;
    logic needWb;
  } entryStat_t;
endpackage

// File: rtl/walk_entry_check.sv
module walk_entry_check
  import walk_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               isWrite,
  input  logic               isUser,
  input  logic               leafLevel,
  output entryStat_t         stat,
  output logic [ENTRY_W-1:0] updated
);
  logic [ENTRY_W-1:0] setMask;

  always_comb begin
    setMask               = '0;
    setMask[ACCESSED_BIT] = 1'b1;
    setMask[DIRTY_BIT]    = leafLevel && isWrite;
    updated               = entry | setMask;
    stat.present          = entry[PRESENT_BIT];
    stat.permitted        = !(isWrite && !entry[WRITABLE_BIT]) &&
                            !(isUser && !entry[USER_BIT]);
    stat.needWb           = (updated != entry);
  end
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkCtl_t                ctl,
  input  logic [ADDR_W-1:0]       reqVaddr,
  input  logic                    reqWrite,
  input  logic                    reqUser,
  input  logic [ADDR_W-OFF_W-1:0] dirBase,
  input  logic [ADDR_W-1:0]       memRdata,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ADDR_W-1:0]       memWdata,
  output entryStat_t              dirStat,
  output entryStat_t              tblStat,
  output logic                    bigNow,
  output logic                    bigHeld,
  output logic                    fault,
  output logic                    faultNotPresent,
  output logic [ADDR_W-1:0]       faultVaddr,
  output logic                    faultWrite,
  output logic                    faultUser,
  output logic [ADDR_W-1:0]       physAddr,
  output logic [ADDR_W-1:0]       leafEntry
);
  localparam int ENTRY_SHIFT = 2;
  localparam int FRAME_W     = ADDR_W - OFF_W;
  localparam int TBL_IDX_W   = OFF_W - ENTRY_SHIFT;
  localparam int DIR_IDX_W   = ADDR_W - OFF_W - TBL_IDX_W;
  localparam int BIG_OFF_W   = OFF_W + TBL_IDX_W;
  localparam int LEVELS      = 2;

  logic [ADDR_W-1:0]  vaReg;
  logic               wrReg;
  logic               usrReg;
  logic [FRAME_W-1:0] baseReg;
  logic [ADDR_W-1:0]  dirReg;
  logic [ADDR_W-1:0]  tblReg;
  logic               bigReg;
  logic               faultReg;
  logic               missReg;

  entryStat_t        levelStat [LEVELS];
  logic [ADDR_W-1:0] levelUpd  [LEVELS];

  logic [DIR_IDX_W-1:0] dirIdx;
  logic [TBL_IDX_W-1:0] tblIdx;
  logic [ADDR_W-1:0]    dirAddr;
  logic [ADDR_W-1:0]    tblAddr;

  assign dirIdx = vaReg[ADDR_W-1 -: DIR_IDX_W];
  assign tblIdx = vaReg[OFF_W +: TBL_IDX_W];

  assign dirAddr = {baseReg, {OFF_W{1'b0}}} +
                   ADDR_W'({dirIdx, {ENTRY_SHIFT{1'b0}}});
  assign tblAddr = {dirReg[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} +
                   ADDR_W'({tblIdx, {ENTRY_SHIFT{1'b0}}});

  // level 0 = directory (leaf only when big-page), level 1 = table (always leaf)
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    logic leafSel;
    if (lv == 0) begin : g_dir
      assign leafSel = memRdata[BIGPAGE_BIT];
    end else begin : g_tbl
      assign leafSel = 1'b1;
    end
    walk_entry_check #(.ENTRY_W(ADDR_W)) chk_u (
      .entry    (memRdata),
      .isWrite  (wrReg),
      .isUser   (usrReg),
      .leafLevel(leafSel),
      .stat     (levelStat[lv]),
      .updated  (levelUpd[lv])
    );
  end

  assign dirStat = levelStat[0];
  assign tblStat = levelStat[1];
  assign bigNow  = memRdata[BIGPAGE_BIT];
  assign bigHeld = dirReg[BIGPAGE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      baseReg  <= '0;
      dirReg   <= '0;
      tblReg   <= '0;
      bigReg   <= 1'b0;
      faultReg <= 1'b0;
      missReg  <= 1'b0;
    end else begin
      if (ctl.capture) begin
        vaReg    <= reqVaddr;
        wrReg    <= reqWrite;
        usrReg   <= reqUser;
        baseReg  <= dirBase;
        bigReg   <= 1'b0;
        faultReg <= 1'b0;
        missReg  <= 1'b0;
      end
      if (ctl.loadDir)   dirReg <= levelUpd[0];
      if (ctl.loadTbl)   tblReg <= levelUpd[1];
      if (ctl.markBig)   bigReg <= 1'b1;
      if (ctl.raiseMiss) begin
        faultReg <= 1'b1;
        missReg  <= 1'b1;
      end
      if (ctl.raiseProt) begin
        faultReg <= 1'b1;
        missReg  <= 1'b0;
      end
    end
  end

  assign memAddr  = ctl.selTbl ? tblAddr : dirAddr;
  assign memWdata = ctl.selTbl ? tblReg : dirReg;

  assign fault           = faultReg;
  assign faultNotPresent = missReg;
  assign faultVaddr      = vaReg;
  assign faultWrite      = wrReg;
  assign faultUser       = usrReg;

  assign physAddr  = bigReg ? {dirReg[ADDR_W-1:BIG_OFF_W], vaReg[BIG_OFF_W-1:0]}
                            : {tblReg[ADDR_W-1:OFF_W], vaReg[OFF_W-1:0]};
  assign leafEntry = bigReg ? dirReg : tblReg;
endmodule

// File: rtl/walk_control.sv
module walk_control
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memAck,
  input  entryStat_t dirStat,
  input  entryStat_t tblStat,
  input  logic       bigNow,
  input  logic       bigHeld,
  output walkCtl_t   ctl,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          nextState   = ST_DIR_RD;
        end
      end
      ST_DIR_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          if (!dirStat.present) begin
            ctl.raiseMiss = 1'b1;
            nextState     = ST_DONE;
          end else if (!dirStat.permitted) begin
            ctl.raiseProt = 1'b1;
            nextState     = ST_DONE;
          end else begin
            ctl.loadDir = 1'b1;
            if (dirStat.needWb) begin
              nextState = ST_DIR_WB;
            end else if (bigNow) begin
              ctl.markBig = 1'b1;
              nextState   = ST_DONE;
            end else begin
              nextState = ST_TBL_RD;
            end
          end
        end
      end
      ST_DIR_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (bigHeld) begin
            ctl.markBig = 1'b1;
            nextState   = ST_DONE;
          end else begin
            nextState = ST_TBL_RD;
          end
        end
      end
      ST_TBL_RD: begin
        memReq     = 1'b1;
        ctl.selTbl = 1'b1;
        if (memAck) begin
          if (!tblStat.present) begin
            ctl.raiseMiss = 1'b1;
            nextState     = ST_DONE;
          end else if (!tblStat.permitted) begin
            ctl.raiseProt = 1'b1;
            nextState     = ST_DONE;
          end else begin
            ctl.loadTbl = 1'b1;
            nextState   = tblStat.needWb ? ST_TBL_WB : ST_DONE;
          end
        end
      end
      ST_TBL_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.selTbl = 1'b1;
        if (memAck) nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqVaddr,
  input  logic                    reqWrite,
  input  logic                    reqUser,
  input  logic [ADDR_W-OFF_W-1:0] dirBase,
  output logic                    busy,
  output logic                    done,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ADDR_W-1:0]       memWdata,
  input  logic                    memAck,
  input  logic [ADDR_W-1:0]       memRdata,
  output logic                    fault,
  output logic                    faultNotPresent,
  output logic [ADDR_W-1:0]       faultVaddr,
  output logic                    faultWrite,
  output logic                    faultUser,
  output logic [ADDR_W-1:0]       physAddr,
  output logic [ADDR_W-1:0]       leafEntry
);
  walkCtl_t   ctl;
  entryStat_t dirStat;
  entryStat_t tblStat;
  logic       bigNow;
  logic       bigHeld;

  walk_control ctrl_u (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .memAck  (memAck),
    .dirStat (dirStat),
    .tblStat (tblStat),
    .bigNow  (bigNow),
    .bigHeld (bigHeld),
    .ctl     (ctl),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .done    (done)
  );

  walk_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dp_u (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .reqVaddr       (reqVaddr),
    .reqWrite       (reqWrite),
    .reqUser        (reqUser),
    .dirBase        (dirBase),
    .memRdata       (memRdata),
    .memAddr        (memAddr),
    .memWdata       (memWdata),
    .dirStat        (dirStat),
    .tblStat        (tblStat),
    .bigNow         (bigNow),
    .bigHeld        (bigHeld),
    .fault          (fault),
    .faultNotPresent(faultNotPresent),
    .faultVaddr     (faultVaddr),
    .faultWrite     (faultWrite),
    .faultUser      (faultUser),
    .physAddr       (physAddr),
    .leafEntry      (leafEntry)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busy,
  input logic                    done,
  input logic                    memReq,
  input logic                    memWe,
  input logic [ADDR_W-1:0]       memAddr,
  input logic [ADDR_W-1:0]       memWdata,
  input logic [ADDR_W-OFF_W-1:0] dirBase,
  input logic                    fault,
  input logic                    faultWrite,
  input logic [ADDR_W-1:0]       leafEntry
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R10
  req_in_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy && !done);

  // R1
  dir_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> memReq && !memWe && (memAddr[ADDR_W-1:OFF_W] == dirBase));

  // R4
  accessed_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWdata[5]);

  // R5
  dirty_leaf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && faultWrite) |-> leafEntry[6]);
endmodule

bind page_walker walk_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (.*);

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [19:0] dirBase = '0;
  logic        busy, done, memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic        fault, faultNotPresent, faultWrite, faultUser;
  logic [31:0] faultVaddr, physAddr, leafEntry;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [logic [31:0]];
  logic        stallMode = 1'b0;
  logic        stall = 1'b0;
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] rdAddr0 = '0;
  logic [31:0] rdAddr1 = '0;

  always #10 clk = ~clk;

  page_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .dirBase(dirBase),
    .busy(busy), .done(done), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .fault(fault), .faultNotPresent(faultNotPresent),
    .faultVaddr(faultVaddr), .faultWrite(faultWrite), .faultUser(faultUser),
    .physAddr(physAddr), .leafEntry(leafEntry)
  );

  function automatic logic [31:0] peek(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory model: response driven away from the active edge
  always @(negedge clk) begin
    stall    <= stallMode ? ~stall : 1'b0;
    memAck   <= memReq && !(stallMode && !stall);
    memRdata <= peek(memAddr);
  end

  always @(posedge clk) begin
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr] = memWdata;
        wrCount++;
      end else begin
        if (rdCount == 0) rdAddr0 = memAddr;
        if (rdCount == 1) rdAddr1 = memAddr;
        rdCount++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic denied(input logic [31:0] e, input logic wr, input logic us);
    return (wr && !e[1]) || (us && !e[2]);
  endfunction

  task automatic doWalk(input logic [19:0] base, input logic [31:0] va,
                        input logic wr, input logic us,
                        input logic [31:0] pdeW, input logic [31:0] pteW,
                        input logic stallOn);
    logic [31:0] pdeA, pteA, expPde, expPte, expPa, expLeaf;
    logic        expFault, expMiss;
    int          expReads, expWrites, cyc;
    logic        busyDrop;
    pdeA = {base, va[31:22], 2'b00};
    pteA = {pdeW[31:12], va[21:12], 2'b00};
    mem.delete();
    mem[pdeA] = pdeW;
    mem[pteA] = pteW;
    rdCount = 0; wrCount = 0; stallMode = stallOn;

    expPde = pdeW; expPte = pteW; expReads = 1; expWrites = 0;
    expFault = 1'b0; expMiss = 1'b0; expPa = '0; expLeaf = '0;
    if (!pdeW[0]) begin
      expFault = 1'b1; expMiss = 1'b1;
    end else if (denied(pdeW, wr, us)) begin
      expFault = 1'b1;
    end else begin
      expPde = pdeW | 32'h20 | ((pdeW[7] && wr) ? 32'h40 : 32'h0);
      if (expPde != pdeW) expWrites++;
      if (pdeW[7]) begin
        expPa = {pdeW[31:22], va[21:0]}; expLeaf = expPde;
      end else begin
        expReads = 2;
        if (!pteW[0]) begin
          expFault = 1'b1; expMiss = 1'b1;
        end else if (denied(pteW, wr, us)) begin
          expFault = 1'b1;
        end else begin
          expPte = pteW | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (expPte != pteW) expWrites++;
          expPa = {pteW[31:12], va[11:0]}; expLeaf = expPte;
        end
      end
    end

    dirBase = base; reqVaddr = va; reqWrite = wr; reqUser = us; reqValid = 1'b1;
    @(negedge clk);
    check("R10 busy after accept", {31'b0, busy}, 32'h1);
    // R10: disturbing inputs while busy must not alter the walk
    reqVaddr = ~va; reqWrite = ~wr; reqUser = ~us;
    cyc = 0; busyDrop = 1'b0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (!done && !busy) busyDrop = 1'b1;
    end
    reqValid = 1'b0;
    check("R10 walk completes", {31'b0, done}, 32'h1);
    check("R10 busy held", {31'b0, busyDrop}, 32'h0);
    check("R7 R8 fault flag", {31'b0, fault}, {31'b0, expFault});
    if (expFault) begin
      check("R7 R8 fault cause", {31'b0, faultNotPresent}, {31'b0, expMiss});
      check("R9 fault record", {faultVaddr[31:2], faultWrite, faultUser},
            {va[31:2], wr, us});
      check("R9 fault offset", {30'b0, faultVaddr[1:0]}, {30'b0, va[1:0]});
    end else begin
      check(pdeW[7] ? "R6 big page address" : "R3 physical address", physAddr, expPa);
      check(pdeW[7] ? "R6 big page entry" : "R3 leaf entry", leafEntry, expLeaf);
    end
    check("R4 R5 R7 R8 directory entry in memory", peek(pdeA), expPde);
    check("R4 R5 R7 R8 table entry in memory", peek(pteA), expPte);
    check("R4 write-back count", wrCount, expWrites);
    check("R6 read count", rdCount, expReads);
    check("R1 directory address", rdAddr0, pdeA);
    if (expReads == 2) check("R2 table address", rdAddr1, pteA);
    @(negedge clk);
    check("R10 done single cycle", {30'b0, done, busy}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {29'b0, busy, done, memReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {29'b0, busy, done, memReq}, 32'h0);
    for (int pf = 0; pf < 32; pf++) begin
      for (int tf = 0; tf < 32; tf++) begin
        for (int mode = 0; mode < 4; mode++) begin
          logic [4:0]  pb, tb;
          logic [31:0] pdeW, pteW, va;
          pb = 5'(pf); tb = 5'(tf);
          pdeW = {10'(300 + tf), 10'(pf * 3 + 1), 12'h0};
          pdeW[0] = pb[0]; pdeW[1] = pb[1]; pdeW[2] = pb[2];
          pdeW[5] = pb[3]; pdeW[7] = pb[4]; pdeW[11:9] = 3'(tf);
          pteW = {20'(32'hA5000 ^ (pf * 64 + tf)), 12'h0};
          pteW[0] = tb[0]; pteW[1] = tb[1]; pteW[2] = tb[2];
          pteW[5] = tb[3]; pteW[6] = tb[4]; pteW[11:9] = 3'(pf);
          va = {10'(pf * 29 + 3), 10'(tf * 37 + 5), 12'(pf * tf * 13 + mode * 401)};
          doWalk(20'h00010 + 20'(mode), va, mode[0], mode[1], pdeW, pteW,
                 1'((pf + tf) % 2));
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule